// File: doc/BRIEF.md
# Per-Buffer Interrupt Flag Register

This block keeps one sticky interrupt flag for each of sixteen message buffers. When a buffer finishes a transmission or a reception, its logic sends a single-cycle pulse that sets the buffer's flag. A second register at its own address holds one enable bit per buffer. The block raises a single interrupt line when any flag is set and its enable bit is also one. The line is registered.

Software clears a flag in two steps. First it reads the flag register and sees the bit as one, which arms that bit. Then it writes a one to the same bit position. Each bit runs a three-state machine:

- `CELL_IDLE`: the flag is zero.
- `CELL_SET`: the flag is one but the bit is not armed.
- `CELL_ARMED`: the flag is one and the bit is armed.

The transitions are:

- Set pulse: `CELL_IDLE` → `CELL_SET`. A set pulse also moves `CELL_ARMED` → `CELL_SET` (disarm).
- Flag read: `CELL_SET` → `CELL_ARMED` (arm).
- Write of one: `CELL_ARMED` → `CELL_IDLE` (clear).
- Write of zero: `CELL_ARMED` → `CELL_SET` (disarm).
- A write always takes priority over a read in the same cycle.

Because of this, a completion that arrives between the read and the write keeps the flag set. Software then sees the flag again on its next read.

The register bus is synchronous. It has an address, a read strobe, a write strobe and write data. Read data is registered.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset, every flag bit, every enable bit, the interrupt output and the read data are zero.
- R2: A one on `set_evt[n]` in a cycle makes flag bit n read as one from the next cycle on.
- R3: A read strobe at address 0 returns the flag vector on `bus_rdata` one cycle later, with bit n for buffer n. Address 1 returns the enable vector in the same way.
- R4: A write to address 0 with data bit n equal to one clears flag n when bit n is armed. Bit n is armed when the last flag read returned it as one, and no set pulse or flag write has touched it since.
- R5: Writing one to an unarmed flag bit, or writing zero to any flag bit, leaves the flag unchanged.
- R6: A set pulse on bit n after the arming read and before the clearing write cancels the clear, so flag n stays one.
- R7: When a set pulse and a clearing write reach the same bit in the same cycle, the flag stays one.
- R8: Any write to address 0 disarms every bit. A later write of one without a new read does not clear.
- R9: The enable register at address 1 is plain read/write, resets to zero, and changes only on a write to address 1.
- R10: `irq` equals the OR over n of (flag n AND enable n), delayed by one register stage.
- R11: A clearing write affects only the bits written as one; other flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_evt | input | 16 | Per-buffer completion pulses |
| bus_addr | input | 4 | Register address: 0 selects flags, 1 selects enables |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after the strobe |
| irq | output | 1 | Combined interrupt request, registered |

## Verification
Flags change on the clock edge that samples a set pulse or a write. Read data appears one edge after the read strobe. The interrupt output follows flags and enables one edge later than that. The monitor notes each read strobe at a falling edge, then compares `bus_rdata` against the queued expectation at the next falling edge, after the capture edge. Interrupt checks are placed at the falling edge that follows the exact number of idle cycles needed to pass the extra register stage. The first check after a set pulse confirms that the line is still low, and the next confirms that it has risen.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    typedef enum logic [1:0] {
        CELL_IDLE  = 2'd0,
        CELL_SET   = 2'd1,
        CELL_ARMED = 2'd2
    } cell_state_e;

endpackage

// File: rtl/irqf_flag_cell.sv
module irqf_flag_cell
    import irqf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);

    cell_state_e state_q;
    cell_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CELL_IDLE;
        else        state_q <= state_d;
    end

    // next state: set beats write, write beats read
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_IDLE: begin
                if (set_i) state_d = CELL_SET;
            end
            CELL_SET: begin
                if (set_i)     state_d = CELL_SET;
                else if (wr_i) state_d = CELL_SET;
                else if (rd_i) state_d = CELL_ARMED;
            end
            CELL_ARMED: begin
                if (set_i)               state_d = CELL_SET;
                else if (wr_i && wbit_i) state_d = CELL_IDLE;
                else if (wr_i)           state_d = CELL_SET;
            end
            default: state_d = CELL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CELL_SET, CELL_ARMED: flag_o = 1'b1;
            default:              flag_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irqf_mask_reg.sv
module irqf_mask_reg #(
    parameter int NBUF = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [NBUF-1:0] wdata_i,
    output logic [NBUF-1:0] mask_o
);

    always_ff @(posedge clk) begin
        if (!rst_n)    mask_o <= '0;
        else if (wr_i) mask_o <= wdata_i;
    end

endmodule

// File: rtl/irqf_bus_dec.sv
module irqf_bus_dec #(
    parameter int NBUF      = 16,
    parameter int AW        = 4,
    parameter int FLAG_ADDR = 0,
    parameter int MASK_ADDR = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr_i,
    input  logic            rd_i,
    input  logic            wr_i,
    input  logic [NBUF-1:0] flag_i,
    input  logic [NBUF-1:0] mask_i,
    output logic            rd_flag_o,
    output logic            wr_flag_o,
    output logic            wr_mask_o,
    output logic [NBUF-1:0] rdata_o
);

    localparam logic [AW-1:0] FlagSel = AW'(FLAG_ADDR);
    localparam logic [AW-1:0] MaskSel = AW'(MASK_ADDR);

    logic hit_flag;
    logic hit_mask;

    assign hit_flag  = (addr_i == FlagSel);
    assign hit_mask  = (addr_i == MaskSel);
    assign rd_flag_o = rd_i && hit_flag;
    assign wr_flag_o = wr_i && hit_flag;
    assign wr_mask_o = wr_i && hit_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            if (hit_flag)      rdata_o <= flag_i;
            else if (hit_mask) rdata_o <= mask_i;
            else               rdata_o <= '0;
        end else begin
            rdata_o <= '0;
        end
    end

endmodule

// File: rtl/irqf_irq_gen.sv
module irqf_irq_gen #(
    parameter int NBUF = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBUF-1:0] flag_i,
    input  logic [NBUF-1:0] mask_i,
    output logic            irq_o
);

    logic [NBUF-1:0] live;

    assign live = flag_i & mask_i;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |live;
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NBUF      = 16,
    parameter int AW        = 4,
    parameter int FLAG_ADDR = 0,
    parameter int MASK_ADDR = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBUF-1:0] set_evt,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic [NBUF-1:0] bus_wdata,
    output logic [NBUF-1:0] bus_rdata,
    output logic            irq
);

    logic            rd_flag;
    logic            wr_flag;
    logic            wr_mask;
    logic [NBUF-1:0] flag_vec;
    logic [NBUF-1:0] mask_vec;

    irqf_bus_dec #(
        .NBUF      (NBUF),
        .AW        (AW),
        .FLAG_ADDR (FLAG_ADDR),
        .MASK_ADDR (MASK_ADDR)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (bus_addr),
        .rd_i      (bus_rd),
        .wr_i      (bus_wr),
        .flag_i    (flag_vec),
        .mask_i    (mask_vec),
        .rd_flag_o (rd_flag),
        .wr_flag_o (wr_flag),
        .wr_mask_o (wr_mask),
        .rdata_o   (bus_rdata)
    );

    for (genvar n = 0; n < NBUF; n++) begin : g_cell
        irqf_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_evt[n]),
            .rd_i   (rd_flag),
            .wr_i   (wr_flag),
            .wbit_i (bus_wdata[n]),
            .flag_o (flag_vec[n])
        );
    end

    irqf_mask_reg #(
        .NBUF (NBUF)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_mask),
        .wdata_i (bus_wdata),
        .mask_o  (mask_vec)
    );

    irqf_irq_gen #(
        .NBUF (NBUF)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (flag_vec),
        .mask_i (mask_vec),
        .irq_o  (irq)
    );

endmodule

// File: rtl/irqf_checker.sv
module irqf_checker #(
    parameter int NBUF      = 16,
    parameter int AW        = 4,
    parameter int FLAG_ADDR = 0,
    parameter int MASK_ADDR = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NBUF-1:0] set_evt,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_wr,
    input logic [NBUF-1:0] bus_wdata,
    input logic [NBUF-1:0] flag_q,
    input logic [NBUF-1:0] mask_q,
    input logic            irq
);

    logic flag_write;
    logic mask_write;

    assign flag_write = bus_wr && (bus_addr == AW'(FLAG_ADDR));
    assign mask_write = bus_wr && (bus_addr == AW'(MASK_ADDR));

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_evt) |=> ((flag_q & $past(set_evt)) == $past(set_evt))); // R2

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_write |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R5

    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_write |=> (($past(flag_q) & ~flag_q & ~$past(bus_wdata)) == '0)); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_evt) |=> (($past(flag_q) & ~flag_q & $past(set_evt)) == '0)); // R7

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_write |=> $stable(mask_q)); // R9

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|mask_q)); // R10

endmodule

bind irq_flag_bank irqf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_evt   (set_evt),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .flag_q    (flag_vec),
    .mask_q    (mask_vec),
    .irq       (irq)
);

// File: tb/sim_irq_flag_bank.sv
module sim_irq_flag_bank;

    localparam int NBUF = 16;
    localparam int AW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NBUF-1:0] set_evt = '0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_rd = 1'b0;
    logic            bus_wr = 1'b0;
    logic [NBUF-1:0] bus_wdata = '0;
    logic [NBUF-1:0] bus_rdata;
    logic            irq;

    always #4 clk = ~clk;   // 125 MHz

    irq_flag_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_evt   (set_evt),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [NBUF-1:0] exp_q[$];
    string           tag_q[$];

    task automatic check(input bit ok, input string tag,
                         input logic [NBUF-1:0] act, input logic [NBUF-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [NBUF-1:0] s, input logic rd, input logic wr,
                         input logic [AW-1:0] a, input logic [NBUF-1:0] d);
        @(posedge clk);
        #1;
        set_evt   = s;
        bus_rd    = rd;
        bus_wr    = wr;
        bus_addr  = a;
        bus_wdata = d;
    endtask

    task automatic idle();
        drive('0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [NBUF-1:0] exp,
                           input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        drive('0, 1'b1, 1'b0, a, '0);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [NBUF-1:0] d);
        drive('0, 1'b0, 1'b1, a, d);
    endtask

    task automatic check_irq(input logic exp, input string tag);
        @(negedge clk);
        check(irq === exp, tag, {{(NBUF-1){1'b0}}, irq}, {{(NBUF-1){1'b0}}, exp});
    endtask

    // monitor: a strobe seen at one falling edge is compared at the next one
    logic            pend = 1'b0;
    logic [NBUF-1:0] m_exp;
    string           m_tag;
    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected read data", bus_rdata, '0);
            end else begin
                m_exp = exp_q.pop_front();
                m_tag = tag_q.pop_front();
                check(bus_rdata === m_exp, m_tag, bus_rdata, m_exp);
            end
        end
        pend = bus_rd;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", '0, '0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(bus_rdata === '0, "R1 read data in reset", bus_rdata, '0);
        check(irq === 1'b0, "R1 irq in reset", {15'd0, irq}, '0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        do_read(0, 16'h0000, "R1 flags after reset");
        do_read(1, 16'h0000, "R1 R9 enables after reset");

        // set and read, arming bits 0 and 2
        drive(16'h0005, 1'b0, 1'b0, 0, '0);
        do_read(0, 16'h0005, "R2 R3 flags after set pulses");
        do_write(0, 16'h0004);
        do_read(0, 16'h0001, "R4 R11 armed clear of bit 2 only");

        // unarmed clear and zero write are ignored
        drive(16'h0100, 1'b0, 1'b0, 0, '0);
        do_write(0, 16'h0100);
        do_write(0, 16'h0000);
        do_read(0, 16'h0101, "R5 unarmed or zero write ignored");

        // any flag write disarms
        do_write(0, 16'h0000);
        do_write(0, 16'h0100);
        do_read(0, 16'h0101, "R8 write disarms all bits");

        // set event between read and write cancels clear
        drive(16'h0100, 1'b0, 1'b0, 0, '0);
        do_write(0, 16'h0101);
        do_read(0, 16'h0100, "R6 R11 intervening set keeps bit 8");

        // set and clear in the same cycle
        drive(16'h0100, 1'b0, 1'b1, 0, 16'h0100);
        do_read(0, 16'h0100, "R7 set beats clear same cycle");
        do_write(0, 16'h0100);
        do_read(0, 16'h0000, "R4 armed clear of bit 8");

        // enables and interrupt
        do_write(1, 16'h0001);
        do_read(1, 16'h0001, "R9 enable readback");
        idle();
        check_irq(1'b0, "R10 no flag no irq");
        drive(16'h0001, 1'b0, 1'b0, 0, '0);
        idle();
        check_irq(1'b0, "R10 irq one stage behind flag");
        idle();
        check_irq(1'b1, "R10 irq raised");
        drive(16'h0002, 1'b0, 1'b0, 0, '0);
        do_write(1, 16'h0004);
        idle();
        idle();
        check_irq(1'b0, "R10 enable on empty flag drops irq");
        do_read(0, 16'h0003, "R9 enable write leaves flags");
        do_write(1, 16'h0002);
        idle();
        idle();
        check_irq(1'b1, "R10 enabled bit 1 raises irq");

        repeat (4) idle();
        @(negedge clk);
        check(exp_q.size() == 0, "R3 all reads answered", 16'(exp_q.size()), '0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule